// File: doc/BRIEF.md
# NAND Flash Access Timing Sequencer

This block runs the strobe phase of a single access to the common memory space of a NAND flash device. A requester raises a start pulse with a direction flag, an address, write data and a 32-bit timing word. The block then holds the address through a setup interval and asserts the active-low write or read strobe for a programmed minimum time. It stretches that strobe while the device's active-low wait line stays low, then holds the address, and the data on writes, for a hold interval. On writes the data bus driver stays off for a programmed number of cycles counted from the start of the access, and it is switched on after that window.

The device wait line arrives asynchronously and passes through a synchronizer before the sequencer uses it. Read data is captured on the clock edge that ends the read strobe. A one-cycle done pulse marks the end of the access. A start request that arrives while an access is running is dropped. The timing word is copied at the start, so a change made to it during the access has no effect until the next one.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset, and during reset, busy_o and done_o are 0, nwe_o and noe_o are 1, and nand_data_oe_o is 0.
- R2: An accepted access begins with a setup phase of setup+1 clock cycles in which busy_o is 1, both strobes are high and nand_addr_o carries the requested address. The setup field is timing_i bits 7:0.
- R3: After setup, exactly one strobe is low: nwe_o for writes (write_i=1) and noe_o for reads (write_i=0). It stays low for at least wait+1 cycles, where the wait field is timing_i bits 15:8.
- R4: When the programmed strobe time ends and the synchronized wait line is low, the strobe stays low until the line is seen high. The synchronizer is two flops, so if nwait_i rises during strobe cycle k, the strobe lasts max(wait+1, k+2) cycles.
- R5: After the strobe rises, the hold phase lasts hold cycles for writes and hold+1 cycles for reads, with busy_o still 1 and the address (and write data) unchanged. The hold field is timing_i bits 23:16. A write with hold 0 has no hold phase.
- R6: On a write, nand_data_oe_o is 0 for the first hiz cycles of the access and 1 in every later busy cycle. The Hi-Z field is timing_i bits 31:24. On a read, nand_data_oe_o is never 1.
- R7: done_o is 1 for exactly one cycle, in the first cycle after the hold phase, with busy_o 0. For a read, rdata_o then holds the value nand_rdata_i had in the last strobe cycle.
- R8: A start request made while busy_o is 1 is ignored. The running access keeps its address, direction and length, and no second access follows.
- R9: The timing word, address, data and direction are taken only in the cycle a start is accepted. Changes to these inputs during the access do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| write_i | input | 1 | 1 = write access, 0 = read access |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| timing_i | input | 32 | Hi-Z[31:24], hold[23:16], wait[15:8], setup[7:0] |
| nwait_i | input | 1 | Asynchronous active-low device wait |
| nand_rdata_i | input | DATA_W | Data bus input from the device |
| nand_addr_o | output | ADDR_W | Address to the device |
| nand_wdata_o | output | DATA_W | Data bus output value |
| nand_data_oe_o | output | 1 | Data bus output enable |
| nwe_o | output | 1 | Active-low write strobe |
| noe_o | output | 1 | Active-low read strobe |
| rdata_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-cycle end-of-access pulse |
| busy_o | output | 1 | Access in progress |

## Verification
On every cycle the assertions check several properties: the data driver is never on while the read strobe is low, done is a single-cycle pulse that comes only while idle, and the latched timing word and address do not move while busy. They also check that every read strobe is followed by a hold phase and that an expired strobe count with the wait line low keeps the strobe asserted. The exact phase lengths cannot be shown by those properties: setup, strobe, stretched strobe and direction-dependent hold. The same holds for where the Hi-Z window ends, the read capture edge, a start dropped during an access, and a reset in mid-access. These are shown only by the bench's scenarios, which count cycles at the ports against values worked out from the fields.

// File: rtl/nand_seq_pkg.sv
// Package: shared types and constants of the NAND strobe sequencer.
// Assumes an 8-bit field width for each of the four timing fields.
package nand_seq_pkg;

    localparam int FIELD_W  = 8;
    localparam int TIMING_W = 4 * FIELD_W;
    localparam int CNT_W    = FIELD_W + 1;

    // Access phase of the sequencer
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    // Timing word; the last member sits in the least significant bits
    typedef struct packed {
        logic [FIELD_W-1:0] hiz;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] strb;
        logic [FIELD_W-1:0] setup;
    } timing_t;

    // Value of the latched timing copy after reset: 0xFC in every field
    localparam timing_t TIMING_RST = '{
        hiz:   8'hFC,
        hold:  8'hFC,
        strb:  8'hFC,
        setup: 8'hFC
    };

endpackage

// File: rtl/nand_wait_sync.sv
// Module: multi-flop synchronizer for the asynchronous active-low wait line.
// Assumes the line is level-like; resets to the inactive (high) level.
module nand_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the line one flop further toward the clock domain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[g] <= 1'b1;
                end else begin
                    if (g == 0) begin
                        stage_q[g] <= async_i;
                    end else begin
                        stage_q[g] <= stage_q[(g > 0) ? g - 1 : 0];
                    end
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/nand_phase_fsm.sv
// Module: phase sequencer for one NAND common-space access.
// Counts setup, strobe and hold with one shared down-counter, runs the
// Hi-Z window on its own counter, latches the timing word at start.
// Assumes nwait_s is already synchronous to clk.
module nand_phase_fsm
    import nand_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                write_i,
    input  logic [TIMING_W-1:0] timing_i,
    input  logic                nwait_s,
    output logic                accept_o,
    output logic                capture_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                nwe_o,
    output logic                noe_o,
    output logic                oe_o
);

    phase_e             ph_q;
    timing_t            tim_q;
    timing_t            tim_in;
    logic [CNT_W-1:0]   cnt_q;
    logic [FIELD_W-1:0] hiz_q;
    logic               wr_q;
    logic               done_q;
    logic               cnt_zero;
    logic               strobe_leave;
    logic [CNT_W-1:0]   hold_len;

    assign tim_in       = timing_t'(timing_i);
    assign accept_o     = start_i && (ph_q == PH_IDLE);
    assign cnt_zero     = (cnt_q == '0);
    assign strobe_leave = (ph_q == PH_STROBE) && cnt_zero && nwait_s;
    assign capture_o    = strobe_leave && !wr_q;

    // Hold length depends on direction: reads get one extra cycle
    always_comb begin
        hold_len = {1'b0, tim_q.hold} + (wr_q ? CNT_W'(0) : CNT_W'(1));
    end

    // Phase register, shared counter, latched timing and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            tim_q  <= TIMING_RST;
            wr_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph_q)
                PH_IDLE: begin
                    if (start_i) begin
                        tim_q <= tim_in;
                        wr_q  <= write_i;
                        cnt_q <= {1'b0, tim_in.setup};
                        ph_q  <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        cnt_q <= {1'b0, tim_q.strb};
                        ph_q  <= PH_STROBE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (!cnt_zero) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (nwait_s) begin
                        if (hold_len == '0) begin
                            ph_q   <= PH_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            cnt_q <= hold_len - 1'b1;
                            ph_q  <= PH_HOLD;
                        end
                    end
                end
                default: begin
                    if (cnt_zero) begin
                        ph_q   <= PH_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // Hi-Z window counter, counted from the accept edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hiz_q <= '0;
        end else if (accept_o) begin
            hiz_q <= tim_in.hiz;
        end else if (hiz_q != '0) begin
            hiz_q <= hiz_q - 1'b1;
        end
    end

    // Output decode of the registered phase
    always_comb begin
        busy_o = (ph_q != PH_IDLE);
        done_o = done_q;
        nwe_o  = !((ph_q == PH_STROBE) && wr_q);
        noe_o  = !((ph_q == PH_STROBE) && !wr_q);
        oe_o   = wr_q && busy_o && (hiz_q == '0);
    end

    // R4: expired strobe count with wait low keeps the strobe phase
    p_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_STROBE && cnt_zero && !nwait_s) |=> (ph_q == PH_STROBE));

    // R5: a read strobe is always followed by a hold phase
    p_read_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_STROBE && !wr_q) ##1 (ph_q != PH_STROBE) |-> (ph_q == PH_HOLD));

    // R7: done lasts a single cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R9: latched timing stays frozen across busy cycles
    p_timing_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(tim_q));

endmodule

// File: rtl/nand_data_path.sv
// Module: address, write-data and read-data registers of the sequencer.
// Assumes accept_i and capture_i come from the phase sequencer.
module nand_data_path #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              capture_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // Latch address and write data when an access is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept_i) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
        end
    end

    // Capture device data on the edge that ends the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture_i) begin
            rdata_q <= rdata_i;
        end
    end

    assign addr_o  = addr_q;
    assign wdata_o = wdata_q;
    assign rdata_o = rdata_q;

    // R8: address cannot move while an access is running
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i)) |-> $stable(addr_q));

endmodule

// File: rtl/nand_strobe_seq.sv
// Module: top of the NAND common-space access timing sequencer.
// Joins the wait synchronizer, the phase sequencer and the data registers.
// Assumes the timing word is held by the caller at least in the start cycle.
module nand_strobe_seq
    import nand_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                write_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [TIMING_W-1:0] timing_i,
    input  logic                nwait_i,
    input  logic [DATA_W-1:0]   nand_rdata_i,
    output logic [ADDR_W-1:0]   nand_addr_o,
    output logic [DATA_W-1:0]   nand_wdata_o,
    output logic                nand_data_oe_o,
    output logic                nwe_o,
    output logic                noe_o,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                done_o,
    output logic                busy_o
);

    logic nwait_s;
    logic accept;
    logic capture;

    nand_wait_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (nwait_i),
        .sync_o  (nwait_s)
    );

    nand_phase_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .write_i   (write_i),
        .timing_i  (timing_i),
        .nwait_s   (nwait_s),
        .accept_o  (accept),
        .capture_o (capture),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .nwe_o     (nwe_o),
        .noe_o     (noe_o),
        .oe_o      (nand_data_oe_o)
    );

    nand_data_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .capture_i (capture),
        .busy_i    (busy_o),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_i   (nand_rdata_i),
        .addr_o    (nand_addr_o),
        .wdata_o   (nand_wdata_o),
        .rdata_o   (rdata_o)
    );

    // R6: the data driver is never on while the read strobe is low
    p_oe_read_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !noe_o |-> !nand_data_oe_o);

    // R7: done only appears while idle
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: tb/test_nand_strobe_seq.sv
`timescale 1ns/1ps
// Bench: vector table of accesses walked by one loop, then directed tests.
module test_nand_strobe_seq;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int WATCHDOG = 100000;

    typedef struct packed {
        logic        wr;
        logic [7:0]  s;
        logic [7:0]  w;
        logic [7:0]  h;
        logic [7:0]  z;
        logic [7:0]  rel;
        logic [15:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'd2,  8'd3,  8'd2, 8'd1,  8'd0, 16'h1234, 8'hA5},
        '{1'b0, 8'd0,  8'd0,  8'd0, 8'd5,  8'd0, 16'h00FF, 8'h3C},
        '{1'b1, 8'd0,  8'd0,  8'd0, 8'd0,  8'd0, 16'hBEEF, 8'h5A},
        '{1'b0, 8'd4,  8'd2,  8'd3, 8'd0,  8'd6, 16'h4321, 8'hC3},
        '{1'b1, 8'd1,  8'd1,  8'd1, 8'd9,  8'd4, 16'h0F0F, 8'h81},
        '{1'b1, 8'd3,  8'd5,  8'd2, 8'd4,  8'd2, 16'hA0A0, 8'h7E},
        '{1'b0, 8'd1,  8'd7,  8'd4, 8'd0,  8'd0, 16'h5555, 8'h96},
        '{1'b1, 8'd20, 8'd10, 8'd6, 8'd30, 8'd0, 16'hCAFE, 8'h42}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              write_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DATA_W-1:0] wdata_i = '0;
    logic [31:0]       timing_i = '0;
    logic              nwait_i = 1'b1;
    logic [DATA_W-1:0] nand_rdata_i = '0;
    logic [ADDR_W-1:0] nand_addr_o;
    logic [DATA_W-1:0] nand_wdata_o;
    logic              nand_data_oe_o;
    logic              nwe_o;
    logic              noe_o;
    logic [DATA_W-1:0] rdata_o;
    logic              done_o;
    logic              busy_o;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    nand_strobe_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_nand_strobe_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .timing_i(timing_i),
        .nwait_i(nwait_i), .nand_rdata_i(nand_rdata_i),
        .nand_addr_o(nand_addr_o), .nand_wdata_o(nand_wdata_o),
        .nand_data_oe_o(nand_data_oe_o), .nwe_o(nwe_o), .noe_o(noe_o),
        .rdata_o(rdata_o), .done_o(done_o), .busy_o(busy_o)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_checks++;
            n_errors++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, "idle busy", busy_o, 0);
        check(req, "idle nwe", nwe_o, 1);
        check(req, "idle noe", noe_o, 1);
        check(req, "idle oe", nand_data_oe_o, 0);
        check(req, "idle done", done_o, 0);
    endtask

    // One access from the table; counts phases at the ports
    task automatic run_access(input vec_t v);
        int n_set = 0, n_str = 0, n_hold = 0, n_oe = 0, n_tot = 0;
        int bad_addr = 0, bad_oe_pos = 0, wrong_strobe = 0;
        int exp_str, exp_hold, exp_oe;
        @(negedge clk);
        start_i = 1'b1; write_i = v.wr; addr_i = v.addr; wdata_i = v.data;
        timing_i = {v.z, v.h, v.w, v.s};
        nand_rdata_i = v.data;
        if (v.rel != 0) nwait_i = 1'b0;
        @(negedge clk);
        // R9: inputs change right after the accept edge
        start_i = 1'b0; timing_i = 32'hFFFF_FFFF; addr_i = ~v.addr;
        wdata_i = ~v.data; write_i = ~v.wr;
        while (busy_o && n_tot < 2000) begin
            n_tot++;
            if (nand_addr_o != v.addr) bad_addr++;
            if (v.wr && nand_wdata_o != v.data) bad_addr++;
            if (v.wr ? !noe_o : !nwe_o) wrong_strobe++;
            if (!nwe_o || !noe_o) begin
                n_str++;
                if (n_str == v.rel) nwait_i = 1'b1;
            end else if (n_str == 0) begin
                n_set++;
            end else begin
                n_hold++;
                nand_rdata_i = ~v.data;
            end
            if (nand_data_oe_o) begin
                n_oe++;
                if (n_tot <= v.z) bad_oe_pos++;
            end
            @(negedge clk);
        end
        nwait_i = 1'b1;
        exp_str  = v.w + 1;
        if (v.rel != 0 && v.rel + 2 > exp_str) exp_str = v.rel + 2;
        exp_hold = v.wr ? v.h : v.h + 1;
        exp_oe   = (v.wr && n_tot > v.z) ? n_tot - v.z : 0;
        check("R2", "setup cycles", n_set, v.s + 1);
        check("R2", "address/data held", bad_addr, 0);
        check("R3", "strobe cycles", n_str, exp_str);
        check("R3", "wrong strobe low", wrong_strobe, 0);
        check("R5", "hold cycles", n_hold, exp_hold);
        check("R6", "oe cycles", n_oe, exp_oe);
        check("R6", "oe inside hiz window", bad_oe_pos, 0);
        check("R7", "done at end", done_o, 1);
        if (!v.wr) check("R7", "read data", rdata_o, v.data);
        @(negedge clk);
        check("R7", "done single cycle", done_o, 0);
    endtask

    initial begin
        int n_busy;
        int n_noe;
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // Table walk (R4 stretch via rel, R9 via input changes)
        for (int i = 0; i < NV; i++) begin
            run_access(VECS[i]);
        end

        // R8: start during an access is dropped
        @(negedge clk);
        start_i = 1'b1; write_i = 1'b1; addr_i = 16'h1111; wdata_i = 8'h11;
        timing_i = {8'd0, 8'd1, 8'd1, 8'd4};
        @(negedge clk);
        start_i = 1'b0;
        n_busy = 0; n_noe = 0;
        while (busy_o && n_busy < 200) begin
            n_busy++;
            if (!noe_o) n_noe++;
            check("R8", "address kept", nand_addr_o, 16'h1111);
            if (n_busy == 2) begin
                start_i = 1'b1; write_i = 1'b0; addr_i = 16'h2222;
                timing_i = 32'h0;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        check("R8", "busy length", n_busy, 5 + 2 + 1);
        check("R8", "no read strobe", n_noe, 0);
        @(negedge clk);
        check("R8", "no second access", busy_o, 0);

        // R1: reset in the middle of an access
        start_i = 1'b1; write_i = 1'b1; addr_i = 16'h3333;
        timing_i = {8'd0, 8'd3, 8'd9, 8'd1};
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", "busy before reset", busy_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule